// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It keeps a program counter and a 32-by-32 register file. It decodes each fixed-width instruction word into the controls of one shared datapath. For each instruction class, that decoder chooses the destination register, the second ALU operand, the immediate extension mode and the write-back source.

The core fetches from an instruction memory port and accesses a data memory port. Both ports read combinationally, and the data memory writes on the same clock edge as the core's own state. Seven operations are supported: register add and subtract, OR with an immediate, word load, word store, branch on equal and absolute jump. Every other encoding passes through as a no-op.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, seen on `imem_addr`, to 0 at the next clock edge.
- R2: An instruction that is not a taken branch or a jump advances `imem_addr` by 4 at the next edge.
- R3: Opcode 0x00 with funct 0x20 writes R[rs]+R[rt] into R[rd]. Funct 0x22 writes R[rs]-R[rt] into R[rd]. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R4: Opcode 0x0D writes R[rs] OR the zero-extended imm16 (bits [15:0]) into R[rt].
- R5: Opcode 0x2B drives `dmem_addr` = R[rs] + sign-extended imm16 and `dmem_wdata` = R[rt], and writes no register.
- R6: Opcode 0x23 writes `dmem_rdata`, read at the address R[rs] + sign-extended imm16, into R[rt].
- R7: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm16 × 4) when R[rs] equals R[rt], and to PC+4 otherwise.
- R8: Opcode 0x02 sets the next PC to {PC[31:28], target[25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: An undefined opcode, or opcode 0x00 with a funct other than 0x20 or 0x22, writes no register and no memory, and the PC advances by 4.
- R11: `dmem_we` is high exactly while a store instruction is being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 32 | Data memory read word at `dmem_addr` |

## Verification
The assertions check, on every cycle, the properties that the ports alone reveal. These are the return of the PC to zero after reset, the sequential PC step for every non-control opcode, the jump target, a branch that compares a register with itself, and the match between the store enable and the store opcode. The arithmetic results, zero versus sign extension, register-0 immunity, load write-back and no-op handling all live in register state. Only the bench's program can show them, because it stores computed registers out to memory and compares each store and each fetch address against a scoreboard.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int OPW     = 6;
    localparam int IMMW    = 16;
    localparam int TGTW    = 26;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPW-1:0] OP_LW    = 6'h23;
    localparam logic [OPW-1:0] OP_SW    = 6'h2B;
    localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPW-1:0] OP_J     = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    ext_signed;
        alu_op_e alu_op;
        logic    rf_we;
        logic    mem_we;
        logic    wb_from_mem;
        logic    is_branch;
        logic    is_jump;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic [5:0]     funct,
    output ctrl_t          ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_RTYPE: begin
                if (funct == FN_ADD || funct == FN_SUB) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.rf_we     = 1'b1;
                    ctrl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
                end
            end
            OP_ORI: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_OR;
                ctrl.rf_we    = 1'b1;
            end
            OP_LW: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.ext_signed  = 1'b1;
                ctrl.rf_we       = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OP_SW: begin
                ctrl.b_is_imm   = 1'b1;
                ctrl.ext_signed = 1'b1;
                ctrl.mem_we     = 1'b1;
            end
            OP_BEQ: begin
                ctrl.ext_signed = 1'b1;
                ctrl.alu_op     = ALU_SUB;
                ctrl.is_branch  = 1'b1;
            end
            OP_J: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl.alu_op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs_q [DEPTH];
    logic [DW-1:0] regs_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) regs_d[i] = regs_q[i];
        if (we && wa != '0) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) regs_q[i] <= regs_d[i];
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int RAW = $clog2(NREGS);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [OPW-1:0]  opcode;
    logic [RAW-1:0]  rs, rt, rd;
    logic [5:0]      funct;
    logic [IMMW-1:0] imm;
    logic [TGTW-1:0] tgt;
    ctrl_t           ctrl;
    logic [XLEN-1:0] bus_a, bus_b, ext_imm, alu_b, alu_y, wb_data;
    logic [XLEN-1:0] pc_seq, pc_br;
    logic            alu_zero;
    logic [RAW-1:0]  wr_addr;

    assign opcode = imem_rdata[31:26];
    assign rs     = imem_rdata[25:21];
    assign rt     = imem_rdata[20:16];
    assign rd     = imem_rdata[15:11];
    assign funct  = imem_rdata[5:0];
    assign imm    = imem_rdata[15:0];
    assign tgt    = imem_rdata[25:0];

    sc_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    assign ext_imm = ctrl.ext_signed ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
                                     : {{(XLEN-IMMW){1'b0}}, imm};
    assign wr_addr = ctrl.dst_is_rd ? rd : rt;
    assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;
    assign alu_b   = ctrl.b_is_imm ? ext_imm : bus_b;

    sc_regfile #(.DW(XLEN), .DEPTH(NREGS)) u_rf (
        .clk  (clk),
        .ra_a (rs),
        .ra_b (rt),
        .rd_a (bus_a),
        .rd_b (bus_b),
        .we   (ctrl.rf_we),
        .wa   (wr_addr),
        .wd   (wb_data)
    );

    sc_alu #(.W(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (bus_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign pc_seq = st_q.pc + XLEN'(4);
    assign pc_br  = pc_seq + {ext_imm[XLEN-3:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.pc = '0;
        else if (ctrl.is_jump)
            st_d.pc = {st_q.pc[31:28], tgt, 2'b00};
        else if (ctrl.is_branch && alu_zero)
            st_d.pc = pc_br;
        else
            st_d.pc = pc_seq;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = bus_b;
    assign dmem_we    = ctrl.mem_we;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_rdata,
    input logic            dmem_we
);
    logic [OPW-1:0] op;
    assign op = imem_rdata[31:26];

    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> imem_addr == '0);

    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (op != OP_BEQ && op != OP_J) |=> imem_addr == $past(imem_addr) + 32'd4);

    p_beq_self_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ && imem_rdata[25:21] == imem_rdata[20:16]) |=>
        imem_addr == $past(imem_addr) + 32'd4 +
                     {{14{$past(imem_rdata[15])}}, $past(imem_rdata[15:0]), 2'b00});

    p_jump_tgt_r8: assert property (@(posedge clk) disable iff (rst)
        op == OP_J |=>
        imem_addr == {$past(imem_addr[31:28]), $past(imem_rdata[25:0]), 2'b00});

    p_store_we_r11: assert property (@(posedge clk) disable iff (rst)
        dmem_we == (op == OP_SW));

    p_undef_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SW) |-> !dmem_we);
endmodule

bind sc_core sc_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    always #4 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] q_pc[$];
    logic [31:0] q_sa[$];
    logic [31:0] q_sd[$];
    string       q_pc_tag[$];
    string       q_st_tag[$];

    function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction

    task automatic push_pc(int word, string tag);
        q_pc.push_back(32'(word * 4));
        q_pc_tag.push_back(tag);
    endtask
    task automatic push_store(logic [31:0] a, logic [31:0] d, string tag);
        q_sa.push_back(a);
        q_sd.push_back(d);
        q_st_tag.push_back(tag);
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic monitor_cycle();
        logic [31:0] e;
        string t;
        e = q_pc.pop_front();
        t = q_pc_tag.pop_front();
        check(imem_addr === e, t, imem_addr, e);
        if (dmem_we === 1'b1) begin
            if (q_sa.size() == 0) begin
                check(1'b0, "R11 unexpected store", dmem_addr, 32'h0);
            end else begin
                t = q_st_tag.pop_front();
                e = q_sa.pop_front();
                check(dmem_addr === e, {t, " addr"}, dmem_addr, e);
                e = q_sd.pop_front();
                check(dmem_wdata === e, {t, " data"}, dmem_wdata, e);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
        imem[0]  = enc_i(6'h0D, 0, 1, 16'h1234);
        imem[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
        imem[2]  = enc_r(1, 2, 3, 6'h20);
        imem[3]  = enc_r(1, 2, 4, 6'h22);
        imem[4]  = enc_i(6'h2B, 0, 3, 16'h0010);
        imem[5]  = enc_i(6'h2B, 0, 4, 16'h0014);
        imem[6]  = enc_i(6'h0D, 0, 0, 16'h0055);
        imem[7]  = enc_i(6'h2B, 0, 0, 16'h0018);
        imem[8]  = enc_i(6'h23, 0, 5, 16'h0010);
        imem[9]  = enc_i(6'h2B, 1, 5, 16'hFFFC);
        imem[10] = enc_i(6'h3F, 1, 3, 16'hFFFF);
        imem[11] = enc_r(1, 2, 3, 6'h25);
        imem[12] = enc_i(6'h2B, 0, 3, 16'h001C);
        imem[13] = enc_i(6'h04, 1, 2, 16'h0005);
        imem[14] = enc_i(6'h04, 3, 5, 16'h0002);
        imem[15] = enc_i(6'h2B, 0, 1, 16'h0000);
        imem[16] = enc_i(6'h2B, 0, 1, 16'h0000);
        imem[17] = {6'h02, 26'd20};
        imem[18] = enc_i(6'h2B, 0, 1, 16'h0000);
        imem[19] = enc_i(6'h2B, 0, 1, 16'h0000);
        imem[20] = enc_i(6'h2B, 0, 2, 16'h0020);
        imem[21] = enc_i(6'h04, 0, 0, 16'hFFFF);

        for (int w = 0; w <= 13; w++) push_pc(w, "R2 sequential pc");
        push_pc(14, "R7 beq not taken");
        push_pc(17, "R7 beq taken");
        push_pc(20, "R8 jump target");
        for (int k = 0; k < 8; k++) push_pc(21, "R7 beq self loop");

        push_store(32'h10,   32'h0001_1233, "R3 add result");
        push_store(32'h14,   32'hFFFF_1235, "R3 sub result");
        push_store(32'h18,   32'h0,         "R9 r0 stays zero");
        push_store(32'h1230, 32'h0001_1233, "R6 load/R5 negative offset");
        push_store(32'h1C,   32'h0001_1233, "R10 undefined ops no write");
        push_store(32'h20,   32'h0000_FFFF, "R4 ori zero extend");

        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(imem_addr === 32'h0, "R1 pc at reset", imem_addr, 32'h0);
        check(dmem_we === 1'b0, "R11 no store in reset", 32'(dmem_we), 32'h0);

        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int c = 0; c < 24; c++) begin
            monitor_cycle();
            @(negedge clk); #1;
        end
        check(q_sa.size() == 0, "R5 all stores seen", 32'(q_sa.size()), 32'h0);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk); #1;
        check(imem_addr === 32'h0, "R1 pc after mid-run reset", imem_addr, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule